// File: doc/BRIEF.md
# Half-Duplex Infrared Direction-Change Guard

This block sits beside the UART of an infrared link that shares one optical path for both directions. It watches four single-cycle events from the UART: a transmit buffer load, the end of the last bit of a transmitted character, a detected receive start bit, and the end of the last bit of a received character. From these it drives two levels. `rx_blank` masks the receiver input. `tx_permit` allows a waiting transmission to start. The aim is to keep the receiver from hearing the link's own optical echo, and to keep the transmitter from talking over the far end while that side is turning round.

The guard time is programmable in 100 µs units through `guard_units`. A value above `MAX_UNITS` (100, which is 10 ms) is clamped to `MAX_UNITS`. A value of zero removes the guard. A prescaler of `TICK_CYCLES` clock cycles produces the unit tick. The prescaler restarts every time the guard timer is loaded, so a guard of N units lasts exactly N × `TICK_CYCLES` cycles.

The guard is applied only when the direction changes. A direction-tracking state machine has five states:

- `LINK_IDLE`: no traffic.
- `LINK_TX_SEND`: a character is being transmitted.
- `LINK_TX_GUARD`: the guard runs after a transmission.
- `LINK_RX_RECV`: a character is being received.
- `LINK_RX_GUARD`: the guard runs after a reception.

Its transitions are:

- IDLE→TX_SEND on a buffer load.
- IDLE→RX_RECV on a start bit, which wins if both arrive together.
- TX_SEND→TX_GUARD on the end of the last transmitted bit, or TX_SEND→IDLE when the guard is zero.
- TX_GUARD→TX_SEND on a reload, which cancels the timer.
- TX_GUARD→IDLE on expiry.
- RX_RECV→RX_GUARD on the end of the last received bit. When the guard is zero, RX_RECV goes to IDLE, or to TX_SEND if a transmit is pending.
- RX_GUARD→RX_RECV on a new start bit, which cancels the timer.
- RX_GUARD→IDLE or RX_GUARD→TX_SEND (if a transmit is pending) on expiry.
- Any state→IDLE whenever half-duplex operation is disabled.

Top module: `ir_turnaround_guard`

## Requirements
- R1: While reset is asserted and right after it, `rx_blank` is 0, `tx_permit` is 1 and `guard_busy` is 0.
- R2: With `hd_en` low, `rx_blank` is 0 and `tx_permit` is 1 from the next cycle on, whatever the events. Dropping `hd_en` during a guard ends it the next cycle.
- R3: `rx_blank` is 1 from the cycle after a buffer load until the character ends. After `tx_bit_done`, it stays 1 for exactly N × `TICK_CYCLES` cycles, where N is the clamped guard, and then falls.
- R4: A buffer load during the transmit guard cancels the timer (`guard_busy` goes 0) and keeps `rx_blank` high. A fresh full guard is counted from the next `tx_bit_done`.
- R5: A buffer load seen during reception or the receive guard is held pending. `tx_permit` stays 0 until N × `TICK_CYCLES` cycles after the last `rx_char_done`. The pending transmit then begins, which raises `rx_blank` in the same cycle that `tx_permit` rises.
- R6: A start bit during the receive guard cancels the timer and keeps `tx_permit` low. A fresh full guard is counted from the next `rx_char_done`.
- R7: Values of `guard_units` above 100 give a guard of 100 × `TICK_CYCLES` cycles.
- R8: With `guard_units` = 0 there is no guard. `rx_blank` is 0 the cycle after `tx_bit_done`, and `tx_permit` is 1 the cycle after `rx_char_done`.
- R9: The guard applies only to the opposite direction. `tx_permit` stays 1 through the transmit guard, and a start bit during it has no effect. `rx_blank` and a low `tx_permit` never occur together.
- R10: `guard_busy` is 1 exactly while a guard interval is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd_en | input | 1 | Half-duplex guard enable |
| guard_units | input | CFG_W | Guard time in 100 µs units (clamped to MAX_UNITS) |
| tx_loaded | input | 1 | Pulse: transmit buffer loaded |
| tx_bit_done | input | 1 | Pulse: last bit of a transmitted character sent |
| rx_start | input | 1 | Pulse: receive start bit detected |
| rx_char_done | input | 1 | Pulse: last bit of a received character taken |
| rx_blank | output | 1 | Receiver input masked |
| tx_permit | output | 1 | A transmission may start |
| guard_busy | output | 1 | Guard timer running |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and keeps `MAX_UNITS` = 100 and `CFG_W` = 8. A full 10 ms guard therefore lasts 400 cycles, which makes the clamp of the values 101 and 255 measurable cycle by cycle, alongside zero and small guards in both directions. The short tick also keeps the restart cases (reload during the transmit guard, start bit during the receive guard, transmit loaded mid-reception) within a few dozen cycles, so each resulting interval is timed exactly.

// File: rtl/irtg_pkg.sv
package irtg_pkg;

    // Direction-tracking states of the turnaround guard
    typedef enum logic [2:0] {
        LINK_IDLE     = 3'd0,
        LINK_TX_SEND  = 3'd1,
        LINK_TX_GUARD = 3'd2,
        LINK_RX_RECV  = 3'd3,
        LINK_RX_GUARD = 3'd4
    } link_state_e;

endpackage

// File: rtl/irtg_tick_gen.sv
// Unit-tick prescaler: one tick every TICK_CYCLES cycles while running,
// phase restarted by clear.
module irtg_tick_gen #(
    parameter int TICK_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear || !run) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        tick = run && !clear && (pre_q == LAST);
    end

    // A restarted prescaler gives a full period before its next tick
    assert_clear_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && TICK_CYCLES > 1) |=> !tick);

endmodule

// File: rtl/irtg_guard_timer.sv
// Guard interval counter in unit ticks, with clamping of the programmed value.
module irtg_guard_timer #(
    parameter int CFG_W     = 8,
    parameter int MAX_UNITS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cancel,
    input  logic             tick,
    input  logic [CFG_W-1:0] cfg_units,
    output logic             busy,
    output logic             expire,
    output logic             units_zero
);
    localparam int CNT_W = $clog2(MAX_UNITS + 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_units;
    logic             busy_q;

    always_comb begin
        if (cfg_units > CFG_W'(MAX_UNITS)) begin
            load_units = CNT_W'(MAX_UNITS);
        end else begin
            load_units = CNT_W'(cfg_units);
        end
        units_zero = (cfg_units == '0);
        busy       = busy_q;
        expire     = busy_q && tick && (count_q == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            busy_q  <= 1'b0;
        end else if (cancel) begin
            count_q <= '0;
            busy_q  <= 1'b0;
        end else if (start) begin
            count_q <= load_units;
            busy_q  <= (load_units != '0);
        end else if (busy_q && tick) begin
            if (count_q == CNT_W'(1)) begin
                count_q <= '0;
                busy_q  <= 1'b0;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // Remaining count always lies within 1..MAX_UNITS while running
    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (count_q != '0 && count_q <= CNT_W'(MAX_UNITS)));

    // The sequencer never asks for a zero-length guard
    assert_start_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !units_zero);

endmodule

// File: rtl/irtg_link_fsm.sv
// Direction tracker: decides when a guard starts, is abandoned or ends.
module irtg_link_fsm
    import irtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hd_en,
    input  logic        tx_loaded,
    input  logic        tx_bit_done,
    input  logic        rx_start,
    input  logic        rx_char_done,
    input  logic        units_zero,
    input  logic        expire,
    output link_state_e state,
    output logic        timer_start,
    output logic        timer_cancel,
    output logic        rx_blank,
    output logic        tx_permit
);
    link_state_e state_q, state_d;
    logic        pend_q, pend_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINK_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Next state
    always_comb begin
        state_d      = state_q;
        pend_d       = pend_q;
        timer_start  = 1'b0;
        timer_cancel = 1'b0;
        if (!hd_en) begin
            state_d      = LINK_IDLE;
            pend_d       = 1'b0;
            timer_cancel = 1'b1;
        end else begin
            unique case (state_q)
                LINK_IDLE: begin
                    if (rx_start) begin
                        state_d = LINK_RX_RECV;
                        if (tx_loaded) pend_d = 1'b1;
                    end else if (tx_loaded) begin
                        state_d = LINK_TX_SEND;
                    end
                end
                LINK_TX_SEND: begin
                    if (tx_bit_done && !tx_loaded) begin
                        if (units_zero) begin
                            state_d = LINK_IDLE;
                        end else begin
                            state_d     = LINK_TX_GUARD;
                            timer_start = 1'b1;
                        end
                    end
                end
                LINK_TX_GUARD: begin
                    if (tx_loaded) begin
                        state_d      = LINK_TX_SEND;
                        timer_cancel = 1'b1;
                    end else if (expire) begin
                        state_d = LINK_IDLE;
                    end
                end
                LINK_RX_RECV: begin
                    if (tx_loaded) pend_d = 1'b1;
                    if (rx_char_done) begin
                        if (units_zero) begin
                            state_d = (pend_q || tx_loaded) ? LINK_TX_SEND : LINK_IDLE;
                            pend_d  = 1'b0;
                        end else begin
                            state_d     = LINK_RX_GUARD;
                            timer_start = 1'b1;
                        end
                    end
                end
                LINK_RX_GUARD: begin
                    if (tx_loaded) pend_d = 1'b1;
                    if (rx_start) begin
                        state_d      = LINK_RX_RECV;
                        timer_cancel = 1'b1;
                    end else if (expire) begin
                        state_d = (pend_q || tx_loaded) ? LINK_TX_SEND : LINK_IDLE;
                        pend_d  = 1'b0;
                    end
                end
                default: begin
                    state_d = LINK_IDLE;
                    pend_d  = 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        state     = state_q;
        rx_blank  = (state_q == LINK_TX_SEND) || (state_q == LINK_TX_GUARD);
        tx_permit = !((state_q == LINK_RX_RECV) || (state_q == LINK_RX_GUARD));
    end

    // Disabling the guard frees both directions on the next cycle
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_en |=> (!rx_blank && tx_permit));

    // A pending transmit never survives into the sending state
    assert_pending_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LINK_TX_SEND) |-> !pend_q);

    // Blanking and transmit hold-off are never applied together
    assert_one_direction_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_blank |-> tx_permit);

endmodule

// File: rtl/ir_turnaround_guard.sv
module ir_turnaround_guard
    import irtg_pkg::*;
#(
    parameter int TICK_CYCLES = 12500,
    parameter int CFG_W       = 8,
    parameter int MAX_UNITS   = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd_en,
    input  logic [CFG_W-1:0] guard_units,
    input  logic             tx_loaded,
    input  logic             tx_bit_done,
    input  logic             rx_start,
    input  logic             rx_char_done,
    output logic             rx_blank,
    output logic             tx_permit,
    output logic             guard_busy
);
    link_state_e link_state;
    logic        t_start, t_cancel, t_tick, t_busy, t_expire, t_zero;

    irtg_link_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hd_en        (hd_en),
        .tx_loaded    (tx_loaded),
        .tx_bit_done  (tx_bit_done),
        .rx_start     (rx_start),
        .rx_char_done (rx_char_done),
        .units_zero   (t_zero),
        .expire       (t_expire),
        .state        (link_state),
        .timer_start  (t_start),
        .timer_cancel (t_cancel),
        .rx_blank     (rx_blank),
        .tx_permit    (tx_permit)
    );

    irtg_tick_gen #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_busy),
        .clear (t_start || t_cancel),
        .tick  (t_tick)
    );

    irtg_guard_timer #(
        .CFG_W     (CFG_W),
        .MAX_UNITS (MAX_UNITS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (t_start),
        .cancel     (t_cancel),
        .tick       (t_tick),
        .cfg_units  (guard_units),
        .busy       (t_busy),
        .expire     (t_expire),
        .units_zero (t_zero)
    );

    assign guard_busy = t_busy;

    // Timer activity and guard states stay in step
    assert_busy_matches_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        guard_busy == (link_state == LINK_TX_GUARD || link_state == LINK_RX_GUARD));

    // Blanking ends only on expiry, a zero guard or disable
    assert_blank_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_blank) |-> $past(t_expire || t_zero || !hd_en));

    // Hold-off ends only on expiry, a zero guard or disable
    assert_permit_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_permit) |-> $past(t_expire || t_zero || !hd_en));

    // A reload in the transmit guard drops the timer but keeps blanking
    assert_reload_keeps_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_en && link_state == LINK_TX_GUARD && tx_loaded) |=> (rx_blank && !guard_busy));

    // A start bit in the receive guard drops the timer but keeps hold-off
    assert_restart_holds_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_en && link_state == LINK_RX_GUARD && rx_start) |=> (!tx_permit && !guard_busy));

endmodule

// File: tb/ir_turnaround_guard_test.sv
module ir_turnaround_guard_test;
    localparam int T  = 4;
    localparam int MX = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hd_en = 1'b1;
    logic [7:0] guard_units = 8'd0;
    logic       tx_loaded = 1'b0, tx_bit_done = 1'b0, rx_start = 1'b0, rx_char_done = 1'b0;
    logic       rx_blank, tx_permit, guard_busy;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    ir_turnaround_guard #(.TICK_CYCLES(T), .CFG_W(8), .MAX_UNITS(MX)) uut (
        .clk(clk), .rst_n(rst_n), .hd_en(hd_en), .guard_units(guard_units),
        .tx_loaded(tx_loaded), .tx_bit_done(tx_bit_done), .rx_start(rx_start),
        .rx_char_done(rx_char_done), .rx_blank(rx_blank), .tx_permit(tx_permit),
        .guard_busy(guard_busy)
    );

    // bit 8: 1 = receive direction; bits 7:0 = programmed units
    localparam logic [8:0] VEC [8] = '{
        {1'b0, 8'd1}, {1'b1, 8'd3}, {1'b0, 8'd0}, {1'b1, 8'd0},
        {1'b0, 8'd100}, {1'b1, 8'd101}, {1'b0, 8'd255}, {1'b1, 8'd6}
    };

    function automatic int guard_len(input int u);
        return ((u > MX) ? MX : u) * T;
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0 tx_loaded, 1 tx_bit_done, 2 rx_start, 3 rx_char_done
    task automatic pulse(input int sel);
        case (sel)
            0: tx_loaded = 1'b1;
            1: tx_bit_done = 1'b1;
            2: rx_start = 1'b1;
            default: rx_char_done = 1'b1;
        endcase
        @(negedge clk);
        tx_loaded = 1'b0; tx_bit_done = 1'b0; rx_start = 1'b0; rx_char_done = 1'b0;
    endtask

    // Counts cycles of the guard on the chosen side; mism counts busy mismatches
    task automatic measure(input bit rx_dir, output int n, output int mism);
        n = 0; mism = 0;
        while ((rx_dir ? !tx_permit : rx_blank) && n < 2000) begin
            if (!guard_busy) mism++;
            n++;
            @(negedge clk);
        end
        if (guard_busy) mism++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int n, mm;
        // R1 reset state
        @(negedge clk);
        chk(rx_blank, 0, "R1 blank in reset");
        chk(tx_permit, 1, "R1 permit in reset");
        chk(guard_busy, 0, "R1 busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_blank + 2 * tx_permit + 4 * guard_busy, 2, "R1 after reset");

        // Table of guard lengths in both directions
        for (int i = 0; i < 8; i++) begin
            guard_units = VEC[i][7:0];
            if (VEC[i][8]) begin
                pulse(2);
                chk(tx_permit, 0, "R5 hold-off during reception");
                pulse(3);
            end else begin
                pulse(0);
                chk(rx_blank, 1, "R3 blank while sending");
                pulse(1);
            end
            measure(VEC[i][8], n, mm);
            chk(n, guard_len(int'(VEC[i][7:0])),
                (VEC[i][7:0] == 0) ? "R8 zero guard" :
                (VEC[i][7:0] > MX) ? "R7 clamped guard" :
                VEC[i][8] ? "R5 receive guard length" : "R3 transmit guard length");
            chk(mm, 0, "R10 busy tracks guard");
            repeat (3) @(negedge clk);
        end

        // R4 reload during transmit guard
        guard_units = 8'd5;
        pulse(0); pulse(1);
        repeat (10) @(negedge clk);
        pulse(0);
        repeat (30) @(negedge clk);
        chk(rx_blank, 1, "R4 blank kept after reload");
        chk(guard_busy, 0, "R4 timer cancelled by reload");
        pulse(1);
        measure(1'b0, n, mm);
        chk(n, 20, "R4 full guard after reload");

        // R6 start bit during receive guard
        repeat (3) @(negedge clk);
        pulse(2); pulse(3);
        repeat (10) @(negedge clk);
        pulse(2);
        repeat (30) @(negedge clk);
        chk(tx_permit, 0, "R6 hold-off kept after new start bit");
        pulse(3);
        measure(1'b1, n, mm);
        chk(n, 20, "R6 full guard after new character");

        // R5 transmit loaded mid-reception
        repeat (3) @(negedge clk);
        pulse(2);
        repeat (5) @(negedge clk);
        pulse(0);
        chk(tx_permit, 0, "R5 pending transmit held");
        repeat (5) @(negedge clk);
        pulse(3);
        measure(1'b1, n, mm);
        chk(n, 20, "R5 pending wait length");
        chk(rx_blank, 1, "R5 pending transmit starts");
        pulse(1);
        measure(1'b0, n, mm);

        // R9 start bit during transmit guard has no effect
        repeat (3) @(negedge clk);
        pulse(0); pulse(1);
        pulse(2);
        chk(tx_permit, 1, "R9 permit kept in transmit guard");
        measure(1'b0, n, mm);
        chk(n, 19, "R9 guard unaffected by start bit");
        chk(tx_permit, 1, "R9 no reception entered");

        // R2 guard disabled
        repeat (3) @(negedge clk);
        pulse(0); pulse(1);
        repeat (3) @(negedge clk);
        hd_en = 1'b0;
        @(negedge clk);
        chk(rx_blank, 0, "R2 disable ends guard");
        pulse(0); pulse(1);
        chk(rx_blank, 0, "R2 no blank when disabled");
        pulse(2);
        chk(tx_permit, 1, "R2 no hold-off when disabled");
        hd_en = 1'b1;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule